// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial link endpoint. A small mode register, loaded through a strobe, sets the character format and the bit rate. The format settings are one or two stop bits, an optional parity bit of either sense, and an address-flag mode that inserts one tagged bit after the data. The rate settings are a power-of-four clock prescaler and an 8-bit reload value for a bit-rate counter. That counter produces an oversampling tick, and sixteen ticks make one bit period.

The transmitter takes a byte through a valid/ready handshake. It sends the byte least significant bit first, framed by a low start bit and one or two high stop bits. The receiver synchronises the incoming line and qualifies each start bit at its middle. It then samples every later bit at its centre and presents the byte with its flag bit, a framing error and a parity error. The receiver checks only the first stop bit, so a second stop bit that is low is taken as the start of the next character.

Top module: `async_serial_xcvr`

## Requirements
- R1: After reset the mode register holds all zeros: one stop bit, no parity, flag mode off, prescaler divide-by-1 and reload 0. A bit then lasts 16 clocks, the line `txd` is high, and `tx_ready` is high.
- R2: The clock select picks the prescaler divisor: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. Every transmitted bit lasts exactly 16 × divisor × (reload + 1) clocks.
- R3: A transmitted frame has a low start bit, then the 8 data bits LSB first, then the stop bit or bits, all high. `tx_ready` is low from the accepting clock edge until the last stop bit has finished. The line is high whenever no frame is being sent.
- R4: With the stop-length bit at 0, one stop bit is sent. With it at 1, two stop bits are sent. `tx_ready` rises in the first clock after the final stop bit.
- R5: When parity is enabled and flag mode is off, a parity bit follows the data. Its value is the XOR of the data bits, XORed with the odd-select bit (0 selects even parity, 1 selects odd parity).
- R6: In flag mode, the bit after the data is `tx_mpb`, and no parity bit is sent, whatever the parity settings are.
- R7: The receiver assembles the data LSB first. It raises `rx_valid` for one clock during the first stop bit. `rx_data`, `rx_mpb` and both error flags hold their values until the next `rx_valid`.
- R8: A falling edge produces no character if the line is high again by the middle of the start bit.
- R9: `rx_frame_err` is set only when the first stop bit samples low. With two stop bits selected, a low level in the second stop position starts the next character and raises no error.
- R10: When parity is enabled and flag mode is off, the received parity bit is checked with the sense given in R5. A mismatch sets `rx_par_err`.
- R11: In flag mode, the received bit after the data is reported on `rx_mpb`, and `rx_par_err` stays 0 whatever the parity settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the mode register from the cfg_* inputs |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_mp | input | 1 | Flag-bit mode, which overrides parity |
| cfg_clk_sel | input | 2 | Prescaler select (divide by 1, 4, 16, 64) |
| cfg_reload | input | 8 | Bit-rate counter reload value |
| tx_data | input | 8 | Byte to transmit |
| tx_mpb | input | 1 | Flag bit to transmit in flag mode |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Last received byte |
| rx_mpb | output | 1 | Flag bit of the last received byte |
| rx_valid | output | 1 | One-clock pulse for each received character |
| rx_frame_err | output | 1 | First stop bit sampled low |
| rx_par_err | output | 1 | Parity mismatch |

## Verification
The transmit path is exact to the clock. The bench anchors on the first clock in which `txd` is low and then predicts every bit at offset i from that anchor: bit number floor(i / (16·P)), where P = divisor × (reload + 1). It also predicts that `tx_ready` stays low through clock 16·P·n − 1 of an n-bit frame and is high at clock 16·P·n, and it compares both signals on every clock. On the receive side the exact clock depends on where the oversampling tick falls relative to the line, so the bench drives each bit for 16·P clocks and counts the `rx_valid` pulses at every clock. It then checks the number of characters and their fields 32·P clocks after the line returns high. By that point the character is due, since it is reported in the middle of the first stop bit.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef struct packed {
    logic       two_stop;
    logic       par_en;
    logic       par_odd;
    logic       mp;
    logic [1:0] clk_sel;
  } sx_mode_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_HOLD  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sx_rate_gen.sv
module sx_rate_gen #(
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          clk_sel,
  input  logic [RELOAD_W-1:0] reload,
  output logic                os_tick
);
  localparam int unsigned PRE_W = 6;

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [RELOAD_W-1:0] brc_q, brc_d;
  logic [PRE_W-1:0]    pre_mask;
  logic                pre_tick;

  always_comb begin
    unique case (clk_sel)
      2'b00:   pre_mask = 6'h00;
      2'b01:   pre_mask = 6'h03;
      2'b10:   pre_mask = 6'h0F;
      default: pre_mask = 6'h3F;
    endcase
    pre_tick = ((pre_q & pre_mask) == pre_mask);
    pre_d    = pre_q + 1'b1;
    brc_d    = brc_q;
    if (pre_tick) begin
      brc_d = (brc_q == reload) ? '0 : brc_q + 1'b1;
    end
    os_tick = pre_tick && (brc_q == reload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      brc_q <= '0;
    end else begin
      pre_q <= pre_d;
      brc_q <= brc_d;
    end
  end

  // R2: with any divisor above 1, two ticks are never adjacent
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && clk_sel != 2'b00) |=> (!os_tick || clk_sel != $past(clk_sel)));

endmodule

// File: rtl/sx_tx.sv
module sx_tx
  import sx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  sx_mode_t          mode,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_mpb,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd
);
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam int unsigned CNT_W   = $clog2(OSR);

  tx_state_e          st_q, st_d;
  logic [FRAME_W-1:0] frm_q, frm_d, frm_new;
  logic [IDX_W-1:0]   last_q, last_d, last_new;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_nxt;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               txd_q, txd_d;
  logic               has_extra, extra_bit;

  always_comb begin
    has_extra = mode.mp | mode.par_en;
    extra_bit = mode.mp ? tx_mpb : ((^tx_data) ^ mode.par_odd);
    frm_new   = '1;
    frm_new[0] = 1'b0;
    frm_new[DATA_W:1] = tx_data;
    if (has_extra) frm_new[DATA_W+1] = extra_bit;
    last_new = IDX_W'(DATA_W + 1) + IDX_W'(has_extra) + IDX_W'(mode.two_stop);
  end

  always_comb begin
    st_d    = st_q;
    frm_d   = frm_q;
    last_d  = last_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    txd_d   = txd_q;
    idx_nxt = idx_q + 1'b1;
    unique case (st_q)
      TX_IDLE: begin
        txd_d = 1'b1;
        if (tx_valid) begin
          frm_d  = frm_new;
          last_d = last_new;
          st_d   = TX_WAIT;
        end
      end
      TX_WAIT: begin
        if (os_tick) begin
          st_d  = TX_SEND;
          idx_d = '0;
          cnt_d = '0;
          txd_d = frm_q[0];
        end
      end
      default: begin
        if (os_tick) begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_d = '0;
            if (idx_q == last_q) begin
              st_d  = TX_IDLE;
              txd_d = 1'b1;
            end else begin
              idx_d = idx_nxt;
              txd_d = frm_q[idx_nxt];
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      frm_q  <= '1;
      last_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      frm_q  <= frm_d;
      last_q <= last_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      txd_q  <= txd_d;
    end
  end

  assign tx_ready = (st_q == TX_IDLE);
  assign txd      = txd_q;

  // R3: line high while idle
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_IDLE) |-> txd_q);
  // R3: an accepted byte drops ready on the next clock
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R3: the first bit sent is a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SEND && $past(st_q) == TX_WAIT) |-> !txd_q);

endmodule

// File: rtl/sx_rx.sv
module sx_rx
  import sx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  sx_mode_t          mode,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_par_err
);
  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned HALF  = OSR / 2;

  rx_state_e         st_q, st_d;
  logic              s1_q, s2_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  nbit_q, nbit_d, last_bit;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              xb_q, xb_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              mpb_q, mpb_d, vld_q, vld_d, fe_q, fe_d, pe_q, pe_d;
  logic              has_extra;

  always_comb begin
    has_extra = mode.mp | mode.par_en;
    last_bit  = IDX_W'(DATA_W) + IDX_W'(has_extra);
    st_d   = st_q;
    cnt_d  = cnt_q;
    nbit_d = nbit_q;
    shf_d  = shf_q;
    xb_d   = xb_q;
    dat_d  = dat_q;
    mpb_d  = mpb_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    vld_d  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (os_tick && !s2_q) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (os_tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_d  = '0;
            nbit_d = '0;
            st_d   = s2_q ? RX_IDLE : RX_BITS;
          end
        end
      end
      RX_BITS: begin
        if (os_tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_d  = '0;
            nbit_d = nbit_q + 1'b1;
            if (nbit_q < IDX_W'(DATA_W)) begin
              shf_d = {s2_q, shf_q[DATA_W-1:1]};
            end else if (nbit_q == last_bit) begin
              vld_d = 1'b1;
              dat_d = shf_q;
              mpb_d = mode.mp & xb_q;
              fe_d  = !s2_q;
              pe_d  = mode.par_en & !mode.mp &
                      (xb_q != ((^shf_q) ^ mode.par_odd));
              st_d  = s2_q ? RX_IDLE : RX_HOLD;
            end else begin
              xb_d = s2_q;
            end
          end
        end
      end
      default: begin
        if (s2_q) st_d = RX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nbit_q <= '0;
      shf_q  <= '0;
      xb_q   <= 1'b0;
      dat_q  <= '0;
      mpb_q  <= 1'b0;
      vld_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      nbit_q <= nbit_d;
      shf_q  <= shf_d;
      xb_q   <= xb_d;
      dat_q  <= dat_d;
      mpb_q  <= mpb_d;
      vld_q  <= vld_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
    end
  end

  assign rx_data      = dat_q;
  assign rx_mpb       = mpb_q;
  assign rx_valid     = vld_q;
  assign rx_frame_err = fe_q;
  assign rx_par_err   = pe_q;

  // R7: a character is reported as a single-clock pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8: the data phase is entered only after a low mid-start sample
  a_r8_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BITS && $past(st_q) == RX_START) |-> !$past(s2_q));
  // R11: flag mode never reports a parity error
  a_r11_mp_no_par: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode.mp) |-> !rx_par_err);

endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
  import sx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RELOAD_W = 8,
  parameter int unsigned OSR      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic                cfg_two_stop,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_mp,
  input  logic [1:0]          cfg_clk_sel,
  input  logic [RELOAD_W-1:0] cfg_reload,
  input  logic [DATA_W-1:0]   tx_data,
  input  logic                tx_mpb,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd,
  input  logic                rxd,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_mpb,
  output logic                rx_valid,
  output logic                rx_frame_err,
  output logic                rx_par_err
);
  sx_mode_t            mode_q, mode_d;
  logic [RELOAD_W-1:0] rld_q, rld_d;
  logic                os_tick;

  always_comb begin
    mode_d = mode_q;
    rld_d  = rld_q;
    if (cfg_load) begin
      mode_d.two_stop = cfg_two_stop;
      mode_d.par_en   = cfg_par_en;
      mode_d.par_odd  = cfg_par_odd;
      mode_d.mp       = cfg_mp;
      mode_d.clk_sel  = cfg_clk_sel;
      rld_d           = cfg_reload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rld_q  <= '0;
    end else begin
      mode_q <= mode_d;
      rld_q  <= rld_d;
    end
  end

  sx_rate_gen #(.RELOAD_W(RELOAD_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (mode_q.clk_sel),
    .reload  (rld_q),
    .os_tick (os_tick)
  );

  sx_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .mode     (mode_q),
    .tx_data  (tx_data),
    .tx_mpb   (tx_mpb),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  sx_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .mode         (mode_q),
    .rxd          (rxd),
    .rx_data      (rx_data),
    .rx_mpb       (rx_mpb),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .rx_par_err   (rx_par_err)
  );

  // R1: the mode register starts from all zeros
  a_r1_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n)) |-> (mode_q == '0 || $past(cfg_load)));

endmodule

// File: tb/async_serial_xcvr_bench.sv
`timescale 1ns/1ps
module async_serial_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0, cfg_two_stop = 1'b0, cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0, cfg_mp = 1'b0;
  logic [1:0] cfg_clk_sel = 2'b00;
  logic [7:0] cfg_reload = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_mpb = 1'b0, tx_valid = 1'b0, rxd = 1'b1;
  logic       tx_ready, txd, rx_mpb, rx_valid, rx_frame_err, rx_par_err;
  logic [7:0] rx_data;

  int tests = 0, fails = 0, per = 1;
  bit done = 0;
  bit m_two = 0, m_pe = 0, m_odd = 0, m_mp = 0;
  int mon_cnt = 0;
  logic [7:0] mon_data;
  logic mon_mpb, mon_fe, mon_pe, mon_fe_any;

  always #4 clk = ~clk;

  async_serial_xcvr u_async_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_two_stop(cfg_two_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_mp(cfg_mp),
    .cfg_clk_sel(cfg_clk_sel), .cfg_reload(cfg_reload), .tx_data(tx_data),
    .tx_mpb(tx_mpb), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      mon_cnt++;
      mon_data = rx_data;
      mon_mpb  = rx_mpb;
      mon_fe   = rx_frame_err;
      mon_pe   = rx_par_err;
      mon_fe_any = mon_fe_any | rx_frame_err;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_mode(input bit two, input bit pe, input bit odd, input bit mp,
                           input logic [1:0] sel, input int rl);
    @(negedge clk);
    cfg_two_stop = two; cfg_par_en = pe; cfg_par_odd = odd; cfg_mp = mp;
    cfg_clk_sel = sel; cfg_reload = 8'(rl); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_two = two; m_pe = pe; m_odd = odd; m_mp = mp;
    per = (sel == 2'b00 ? 1 : sel == 2'b01 ? 4 : sel == 2'b10 ? 16 : 64) * (rl + 1);
    repeat (4) @(negedge clk);
  endtask

  // frame bits as the requirements define them (start, data LSB first, extra, stops)
  task automatic build(input logic [7:0] d, input bit ext_en, input bit ext,
                       input bit stop, input int nstop,
                       output logic [15:0] e, output int n);
    e = '1; e[0] = 1'b0; n = 9;
    for (int i = 0; i < 8; i++) e[i+1] = d[i];
    if (ext_en) begin e[n] = ext; n++; end
    for (int i = 0; i < nstop; i++) begin e[n] = (i == 0) ? stop : 1'b1; n++; end
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit mpb, input string req);
    logic [15:0] e; int n, bad, first_i, w, len, fact, fexp;
    bit ext;
    ext = m_mp ? mpb : ((^d) ^ m_odd);
    build(d, m_mp | m_pe, ext, 1'b1, m_two ? 2 : 1, e, n);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_mpb = mpb; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    w = 0;
    while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    len = 16 * per * n;
    bad = 0; first_i = -1; fact = 0; fexp = 0;
    for (int i = 0; i < len; i++) begin
      if (txd !== e[i / (16 * per)] || tx_ready !== 1'b0) begin
        if (bad == 0) begin first_i = i; fact = {30'd0, tx_ready, txd}; fexp = {31'd0, e[i / (16 * per)]}; end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, $sformatf("txd/ready per-clock mismatch at offset %0d ({ready,txd})", first_i), fact, fexp);
    check(tx_ready === 1'b1 && txd === 1'b1, "R4", "ready and idle line after last stop",
          {30'd0, tx_ready, txd}, 3);
  endtask

  task automatic drive_bits(input logic [15:0] e, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = e[i];
      repeat (16 * per) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic rx_clear();
    mon_cnt = 0; mon_fe_any = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit ext, input bit stop,
                          output logic [15:0] e, output int n);
    build(d, m_mp | m_pe, ext, stop, m_two ? 2 : 1, e, n);
  endtask

  initial begin
    logic [15:0] e; int n;
    logic [15:0] e2; int n2;
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0, "R1",
          "reset outputs {txd,ready,valid}", {29'd0, txd, tx_ready, rx_valid}, 6);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && tx_ready === 1'b1, "R1", "outputs after reset release",
          {30'd0, txd, tx_ready}, 3);

    // R1 + R3: default mode, 16-clock bits, 10-bit frame
    per = 1;
    tx_frame(8'hA5, 1'b0, "R1");
    // R2 + R4: divide by 4, two stop bits
    load_mode(1, 0, 0, 0, 2'b01, 0);
    tx_frame(8'h3C, 1'b0, "R4");
    // R5: even then odd parity, reload 3 on undivided clock
    load_mode(0, 1, 0, 0, 2'b00, 3);
    tx_frame(8'h07, 1'b0, "R5");
    load_mode(0, 1, 1, 0, 2'b00, 3);
    tx_frame(8'h07, 1'b0, "R5");
    // R6: flag mode overrides parity, divide by 16 with reload 1
    load_mode(0, 1, 1, 1, 2'b10, 1);
    tx_frame(8'h81, 1'b1, "R6");
    // R2: divide by 64
    load_mode(0, 0, 0, 0, 2'b11, 0);
    tx_frame(8'h5A, 1'b0, "R2");
    // R3: plain frame with a different pattern at divide-by-4
    load_mode(0, 0, 0, 0, 2'b01, 0);
    tx_frame(8'hFF, 1'b0, "R3");

    // R7: plain reception
    rx_clear();
    rx_frame(8'hC3, 1'b0, 1'b1, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1, "R7", "character count", mon_cnt, 1);
    check(mon_data == 8'hC3 && !mon_fe && !mon_pe, "R7", "data and flags",
          {22'd0, mon_fe, mon_pe, mon_data}, 8'hC3);

    // R8: short low pulse is not a start bit
    rx_clear();
    rxd = 1'b0;
    repeat (3 * per) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * per * 12) @(negedge clk);
    check(mon_cnt == 0, "R8", "characters after glitch", mon_cnt, 0);

    // R9: low first stop bit
    rx_clear();
    rx_frame(8'h69, 1'b0, 1'b0, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1 && mon_fe == 1'b1, "R9", "frame error on low stop {count,fe}",
          mon_cnt * 2 + mon_fe, 3);
    check(mon_data == 8'h69, "R9", "data with frame error", mon_data, 8'h69);

    // R9: two stop bits selected, second stop low starts next character
    load_mode(1, 0, 0, 0, 2'b01, 0);
    rx_clear();
    build(8'h12, 1'b0, 1'b0, 1'b1, 1, e, n);
    rx_frame(8'h34, 1'b0, 1'b1, e2, n2);
    drive_bits(e, n);
    drive_bits(e2, n2);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 2, "R9", "back-to-back character count", mon_cnt, 2);
    check(mon_fe_any == 1'b0 && mon_data == 8'h34, "R9", "no frame error, second data",
          {23'd0, mon_fe_any, mon_data}, 8'h34);

    // R10: parity good then bad (even parity, 0x0B has three ones so bit = 1)
    load_mode(0, 1, 0, 0, 2'b01, 0);
    rx_clear();
    rx_frame(8'h0B, 1'b1, 1'b1, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1 && mon_pe == 1'b0, "R10", "good parity {count,pe}", mon_cnt * 2 + mon_pe, 2);
    rx_clear();
    rx_frame(8'h0B, 1'b0, 1'b1, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1 && mon_pe == 1'b1, "R10", "bad parity {count,pe}", mon_cnt * 2 + mon_pe, 3);
    check(mon_data == 8'h0B, "R10", "data with parity error", mon_data, 8'h0B);

    // R11: flag mode with parity enabled, flag bit 1 then 0
    load_mode(0, 1, 1, 1, 2'b01, 0);
    rx_clear();
    rx_frame(8'hE4, 1'b1, 1'b1, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1 && mon_mpb == 1'b1 && mon_pe == 1'b0, "R11", "flag 1 {count,mpb,pe}",
          mon_cnt * 4 + mon_mpb * 2 + mon_pe, 6);
    check(mon_data == 8'hE4, "R11", "data in flag mode", mon_data, 8'hE4);
    rx_clear();
    rx_frame(8'h00, 1'b0, 1'b1, e, n);
    drive_bits(e, n);
    repeat (32 * per) @(negedge clk);
    check(mon_cnt == 1 && mon_mpb == 1'b0 && mon_pe == 1'b0 && mon_fe == 1'b0, "R11",
          "flag 0 {count,mpb,pe,fe}", mon_cnt * 8 + mon_mpb * 4 + mon_pe * 2 + mon_fe, 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule